// File: doc/BRIEF.md
# Inverted Frame Table Search Engine

This block turns a 32-bit virtual address into a physical address by searching a table that has one slot per physical frame. Each slot says which virtual page, if any, currently lives in that frame. Because the table is organised by frame and not by page, it cannot be indexed with the page number. Its size follows the amount of physical memory, and a translation has to walk the slots in order until one matches.

A lookup enters through a valid/ready request port and carries the full virtual address. The engine keeps the low 12 bits, which are the offset inside a 4 KB page. It then compares the upper 20 bits, the page number, against one slot per clock, starting at slot 0.

When a valid slot holds that page, the engine returns a physical address. Its upper bits are the slot index and its low 12 bits are the original offset. If no valid slot matches, it returns a fault, which means the page is not resident. Software fills and clears slots through a separate write port. That port is held off while a search is running, so the table never changes under a scan.

Top module: `ift_search`

## Requirements
- R1: After reset, `req_ready` and `wr_ready` are 1, `rsp_valid` is 0, and every slot is invalid, so any lookup faults.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the response cycle, so at most one lookup is in flight. A request held valid across a response is taken again once ready returns.
- R3: If the first valid slot whose page number equals bits 31:12 of the request is slot k, then `rsp_valid` is 1 exactly k+1 cycles after the accepting edge. In that cycle `rsp_fault` is 0 and `rsp_paddr` equals {k, offset}, with k in bits 17:12.
- R4: If no valid slot matches, `rsp_valid` is 1 exactly N_FRAMES cycles after the accepting edge, with `rsp_fault` 1 and `rsp_paddr` 0.
- R5: A slot written with `wr_entry_valid` 0 never matches, even when its stored page number equals the requested one.
- R6: When several valid slots hold the same page number, the lowest slot index is returned.
- R7: While a search runs, `wr_ready` is 0 and a pending write is held. Once the search ends the write lands, and later lookups see it. A write that lands after a request was accepted does not change that request's result.
- R8: `rsp_valid` is a single-cycle pulse for each accepted request, and it is 0 in every other cycle.
- R9: A write and a request accepted on the same edge are ordered write first, so that request sees the new slot contents.
- R10: Bits 11:0 of `rsp_paddr` on a hit equal bits 11:0 of the request address, for any offset value including 0x000 and 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_vaddr | input | 32 | Virtual address: page number in 31:12, offset in 11:0 |
| wr_valid | input | 1 | Slot write present |
| wr_ready | output | 1 | Slot write may be taken this cycle |
| wr_frame | input | log2(N_FRAMES) | Index of the slot to write |
| wr_vpn | input | 20 | Page number stored in the slot |
| wr_entry_valid | input | 1 | Valid bit stored in the slot |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | 1 when no valid slot matched |
| rsp_paddr | output | log2(N_FRAMES)+12 | Slot index and offset on a hit, 0 on a fault |

## Verification
A hit in slot k is due exactly k+1 clocks after the accepting edge. A miss is due after N_FRAMES clocks. Both ready outputs return high in the same cycle as the result strobe.

The bench keeps its own copy of the table. It works out the due cycle at the moment it sees a handshake, as a countdown from the rising edge of acceptance. It then compares the strobe, the fault flag, the address and both ready outputs at every falling edge. A result that comes one cycle early or late, or a ready that drops or rises in the wrong cycle, is therefore caught in the exact cycle it happens.

Writes and requests are applied to the bench's table in the same order the requirements fix. This covers writes stalled behind a scan and a write that lands on the same edge as a request.

// File: rtl/ift_pkg.sv
package ift_pkg;

    localparam int unsigned VA_W  = 32;
    localparam int unsigned OFF_W = 12;
    localparam int unsigned VPN_W = VA_W - OFF_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
    } slot_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic vpn_t page_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic off_t offset_of(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

    function automatic logic slot_hit(input slot_t s, input vpn_t key);
        return s.valid && (s.vpn == key);
    endfunction

endpackage

// File: rtl/ift_slot_store.sv
module ift_slot_store
    import ift_pkg::*;
#(
    parameter int unsigned N_FRAMES = 64,
    localparam int unsigned FRAME_W = $clog2(N_FRAMES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [FRAME_W-1:0] waddr,
    input  slot_t              wdata,
    input  logic [FRAME_W-1:0] raddr,
    output slot_t              rdata
);

    slot_t              slots [N_FRAMES];
    logic [N_FRAMES-1:0] sel;

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_sel
        assign sel[g] = we && (waddr == FRAME_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_FRAMES; i++) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (sel[i]) begin
                slots[i] <= wdata;
            end
        end
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/ift_scan_ctrl.sv
module ift_scan_ctrl
    import ift_pkg::*;
#(
    parameter int unsigned N_FRAMES = 64,
    localparam int unsigned FRAME_W = $clog2(N_FRAMES),
    localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  vpn_t               start_key,
    input  off_t               start_off,
    input  slot_t              cur_slot,
    output logic [FRAME_W-1:0] cur_idx,
    output logic               busy,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr
);

    localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(N_FRAMES - 1);

    scan_state_e state;
    vpn_t        key_q;
    off_t        off_q;
    logic        hit;

    assign hit  = slot_hit(cur_slot, key_q);
    assign busy = (state == ST_SCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_idx   <= '0;
            key_q     <= '0;
            off_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        key_q   <= start_key;
                        off_q   <= start_off;
                        cur_idx <= '0;
                        state   <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_paddr <= {cur_idx, off_q};
                        state     <= ST_IDLE;
                    end else if (cur_idx == LAST_IDX) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b1;
                        rsp_paddr <= '0;
                        state     <= ST_IDLE;
                    end else begin
                        cur_idx <= cur_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ift_search.sv
module ift_search
    import ift_pkg::*;
#(
    parameter int unsigned N_FRAMES = 64,
    localparam int unsigned FRAME_W = $clog2(N_FRAMES),
    localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic               wr_entry_valid,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr
);

    logic               busy;
    logic               req_fire;
    logic               wr_fire;
    logic [FRAME_W-1:0] scan_idx;
    slot_t              scan_slot;
    slot_t              wr_slot;

    assign req_ready = !busy;
    assign wr_ready  = !busy;
    assign req_fire  = req_valid && req_ready;
    assign wr_fire   = wr_valid && wr_ready;

    assign wr_slot.valid = wr_entry_valid;
    assign wr_slot.vpn   = wr_vpn;

    ift_slot_store #(.N_FRAMES(N_FRAMES)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_fire),
        .waddr (wr_frame),
        .wdata (wr_slot),
        .raddr (scan_idx),
        .rdata (scan_slot)
    );

    ift_scan_ctrl #(.N_FRAMES(N_FRAMES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (req_fire),
        .start_key (page_of(req_vaddr)),
        .start_off (offset_of(req_vaddr)),
        .cur_slot  (scan_slot),
        .cur_idx   (scan_idx),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/ift_search_chk.sv
module ift_search_chk
    import ift_pkg::*;
#(
    parameter int unsigned N_FRAMES = 64,
    localparam int unsigned FRAME_W = $clog2(N_FRAMES),
    localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input off_t            req_off,
    input logic            wr_ready,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr
);

    logic [FRAME_W:0] lat;
    off_t             last_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat      <= '0;
            last_off <= '0;
        end else if (req_valid && req_ready) begin
            lat      <= '0;
            last_off <= req_off;
        end else if (!req_ready) begin
            lat <= lat + 1'b1;
        end
    end

    a_r2_accept_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_rsp_after_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!req_ready));

    a_r7_write_held: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !wr_ready);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r4_miss_latency: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (lat == (FRAME_W+1)'(N_FRAMES)));

    a_r4_fault_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    a_r4_scan_bounded: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (lat < (FRAME_W+1)'(N_FRAMES)));

    a_r3_hit_index: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PA_W-1:OFF_W] == FRAME_W'(lat - 1'b1)));

    a_r10_offset: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == last_off));

endmodule

bind ift_search ift_search_chk #(.N_FRAMES(N_FRAMES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_vaddr[ift_pkg::OFF_W-1:0]),
    .wr_ready  (wr_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/test_ift_search.sv
module test_ift_search;
    import ift_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 64;
    localparam int FW         = $clog2(NF);
    localparam int PA_W       = FW + OFF_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            wr_valid = 1'b0;
    logic            wr_ready;
    logic [FW-1:0]   wr_frame = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic            wr_entry_valid = 1'b0;
    logic            rsp_valid;
    logic            rsp_fault;
    logic [PA_W-1:0] rsp_paddr;

    ift_search #(.N_FRAMES(NF)) i_ift_search (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .wr_valid       (wr_valid),
        .wr_ready       (wr_ready),
        .wr_frame       (wr_frame),
        .wr_vpn         (wr_vpn),
        .wr_entry_valid (wr_entry_valid),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (rsp_fault),
        .rsp_paddr      (rsp_paddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    // Behavioural reference: table contents plus a countdown to the due result.
    bit              m_v   [NF];
    vpn_t            m_vpn [NF];
    bit              m_busy = 1'b0;
    int              m_left = 0;
    bit              m_fault = 1'b0;
    int              m_idx = 0;
    off_t            m_off = '0;
    bit              e_rsp = 1'b0;
    bit              e_fault = 1'b0;
    logic [PA_W-1:0] e_paddr = '0;

    always @(posedge clk) begin
        bit rdy;
        if (rst) begin
            for (int i = 0; i < NF; i++) begin
                m_v[i]   = 1'b0;
                m_vpn[i] = '0;
            end
            m_busy = 1'b0;
            e_rsp  = 1'b0;
        end else begin
            rdy   = !m_busy;
            e_rsp = 1'b0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    e_rsp   = 1'b1;
                    e_fault = m_fault;
                    e_paddr = m_fault ? '0 : {m_idx[FW-1:0], m_off};
                    m_busy  = 1'b0;
                end
            end
            if (wr_valid && rdy) begin
                m_v[wr_frame]   = wr_entry_valid;
                m_vpn[wr_frame] = wr_vpn;
            end
            if (req_valid && rdy) begin
                m_fault = 1'b1;
                for (int i = 0; i < NF; i++) begin
                    if (m_fault && m_v[i] && m_vpn[i] == page_of(req_vaddr)) begin
                        m_fault = 1'b0;
                        m_idx   = i;
                    end
                end
                m_off  = offset_of(req_vaddr);
                m_left = m_fault ? NF : m_idx + 1;
                m_busy = 1'b1;
            end
        end
    end

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(64'(req_ready), 64'(!m_busy), "req_ready");
            check(64'(wr_ready),  64'(!m_busy), "wr_ready");
            check(64'(rsp_valid), 64'(e_rsp),   "rsp_valid");
            if (e_rsp) begin
                check(64'(rsp_fault), 64'(e_fault), "rsp_fault");
                check(64'(rsp_paddr), 64'(e_paddr), "rsp_paddr");
            end
        end
    end

    task automatic slot_write(input int f, input vpn_t v, input bit en);
        @(negedge clk);
        wr_valid       = 1'b1;
        wr_frame       = FW'(f);
        wr_vpn         = v;
        wr_entry_valid = en;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic issue(input logic [VA_W-1:0] va);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic lookup(input logic [VA_W-1:0] va);
        issue(va);
        wait_idle();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog %s run did not complete", tag);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        check(64'(req_ready), 64'd1, "reset req_ready");
        check(64'(wr_ready),  64'd1, "reset wr_ready");
        check(64'(rsp_valid), 64'd0, "reset rsp_valid");
        lookup(32'h0000_0123);
        lookup(32'h0000_0000);

        tag = "R3";
        slot_write(5, 20'h12345, 1'b1);
        slot_write(0, 20'h00042, 1'b1);
        slot_write(NF-1, 20'hFFFFF, 1'b1);
        lookup(32'h1234_5ABC);
        lookup(32'h0004_2777);
        lookup(32'hFFFF_F001);

        tag = "R4";
        lookup(32'h5555_5000);

        tag = "R5";
        slot_write(10, 20'h0BEEF, 1'b0);
        lookup(32'h0BEE_F010);
        slot_write(5, 20'h12345, 1'b0);
        lookup(32'h1234_5ABC);

        tag = "R6";
        slot_write(20, 20'h0CAFE, 1'b1);
        slot_write(7,  20'h0CAFE, 1'b1);
        lookup(32'h0CAF_E321);

        tag = "R10";
        lookup(32'h0CAF_E000);
        lookup(32'h0CAF_EFFF);

        tag = "R7";
        issue(32'h0ABCD_456 << 0);
        slot_write(50, 20'hABCD4, 1'b1);
        wait_idle();
        lookup(32'hABCD_4456);

        tag = "R9";
        @(negedge clk);
        req_valid      = 1'b1;
        req_vaddr      = 32'h0777_7888;
        wr_valid       = 1'b1;
        wr_frame       = FW'(3);
        wr_vpn         = 20'h07777;
        wr_entry_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wr_valid  = 1'b0;
        wait_idle();

        tag = "R2";
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 32'h0004_2AAA;
        @(negedge clk);
        req_vaddr = 32'h0777_7BBB;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        tag = "R8";
        lookup(32'h0000_0FFF);
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule